// File: doc/BRIEF.md
# RMII Receive Dibit Assembler

This block sits on the MAC side of a Reduced MII link and turns the PHY's 2-bit receive stream into octets for a byte-wide MAC receive port. A single 50 MHz reference clock times every input. The combined carrier-sense/data-valid line may rise with no fixed relation to that clock, so it passes through a synchronizer. The receive dibits are delayed by the same number of stages, which keeps them lined up with it.

While carrier is up, the block skips the forced-zero dibits that the PHY sends before it has decoded data. It waits for a preamble (dibit 01, one or more times) that is closed by the start-of-frame dibit 11. Only after that does it pack dibits into octets. When carrier drops, it signals the end of the frame, and it flags an error if the last octet was left incomplete. A mode input selects 10 Mb/s operation. In that mode every dibit is held for ten reference clocks, and the block takes one sample in each period of ten, starting from the first non-zero dibit.

Top module: `rmii_rx_assembler`

## Requirements
- R1: Any effect of an input sampled at clock edge n, whether a completed byte or an end of frame, shows on the outputs just after edge n+2. This is two synchronizer stages plus one output register.
- R2: Zero dibits that follow the rise of carrier-valid produce no byte and do not count toward alignment.
- R3: While carrier-valid is low, non-zero values on the receive pins have no effect, and no output pulses.
- R4: Bytes are assembled only after at least one dibit 01 is followed directly by dibit 11. A frame that never meets this rule produces no byte, no start and no end pulse.
- R5: Counting from the first dibit after the 11, dibit k of each group of four lands in byte bits [2k+1:2k], with bit 0 of the dibit in bit 2k. byte_valid pulses for one cycle with the completed byte.
- R6: frame_start pulses together with byte_valid for the first byte of an aligned frame only.
- R7: When carrier-valid falls after alignment, frame_end pulses for exactly one cycle.
- R8: align_err pulses with frame_end exactly when the number of dibits after the 11 is not a multiple of four. A partial byte is never emitted.
- R9: With rate_10m high, the first sample is taken on the first non-zero dibit after carrier rises, and further samples follow every ten clocks. Bytes are then never closer than forty clocks apart.
- R10: During and right after reset, byte_valid, frame_start, frame_end and align_err are low.
- R11: A dibit 00 or 10 after a preamble dibit breaks the preamble. A fresh 01 is then needed before an 11 can align.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz receive reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_10m | input | 1 | 1 selects 10 Mb/s sampling, 0 selects 100 Mb/s; change only while carrier is low |
| crs_dv_in | input | 1 | Carrier-sense / receive-data-valid from the PHY |
| rxd_in | input | 2 | Receive dibit from the PHY |
| byte_valid | output | 1 | One-cycle strobe: byte_data holds a completed octet |
| byte_data | output | BYTE_W | Assembled octet, LSB received first |
| frame_start | output | 1 | Marks the first octet of an aligned frame |
| frame_end | output | 1 | One-cycle pulse when carrier drops after alignment |
| align_err | output | 1 | With frame_end: the last octet was incomplete |

## Verification
Every result is due exactly three clock edges after the edge that samples its cause. For a byte and a frame start, the cause is the final dibit of the byte, at the first clock of that dibit's hold. For an end of frame and an alignment error, the cause is the first low sample of carrier. The bench sets the expected outputs for each driven cycle at the moment it drives that cycle. It pushes them through a three-slot delay line and compares all four flags, and the byte when valid, on every cycle, so an early, late or extra pulse fails as surely as a wrong value. The expected bytes and alignment points come from a bench function that scans the driven dibit list using the preamble and start-of-frame rule.

// File: rtl/rmii_rx_pkg.sv
// Package: shared constants and state type for the RMII receive assembler.
// Assumes the RMII data path is always two bits wide.
package rmii_rx_pkg;
    localparam int          DIBIT_W        = 2;
    localparam logic [1:0]  DIBIT_PREAMBLE = 2'b01;
    localparam logic [1:0]  DIBIT_SFD      = 2'b11;

    typedef enum logic [1:0] {
        RX_IDLE,   // carrier low
        RX_HUNT,   // carrier up, waiting for a preamble dibit
        RX_PRE,    // inside preamble, waiting for the closing dibit
        RX_DATA    // aligned, packing octets
    } rx_state_e;
endpackage

// File: rtl/rmii_rx_sync.sv
// Module: rmii_rx_sync
// Brings carrier-valid into the clock domain through a flop chain, and delays
// the receive dibit by the same number of stages so both stay aligned.
// Assumes STAGES >= 2 and a synchronous, active-low reset.
module rmii_rx_sync #(
    parameter int STAGES = 2,
    parameter int DW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          crs_in,
    input  logic [DW-1:0] rxd_in,
    output logic          crs_s,
    output logic [DW-1:0] rxd_s
);
    logic [STAGES-1:0] crs_q;
    logic [DW-1:0]     rxd_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        crs_q[0] <= 1'b0;
                        rxd_q[0] <= '0;
                    end else begin
                        crs_q[0] <= crs_in;
                        rxd_q[0] <= rxd_in;
                    end
                end
            end else begin : g_next
                // Shift one stage further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        crs_q[s] <= 1'b0;
                        rxd_q[s] <= '0;
                    end else begin
                        crs_q[s] <= crs_q[s-1];
                        rxd_q[s] <= rxd_q[s-1];
                    end
                end
            end
        end
    endgenerate

    assign crs_s = crs_q[STAGES-1];
    assign rxd_s = rxd_q[STAGES-1];
endmodule

// File: rtl/rmii_rx_strobe.sv
// Module: rmii_rx_strobe
// Decides in which cycles a dibit is taken. At full rate it samples every
// cycle while carrier is up. In slow mode it locks its phase to the first
// non-zero dibit and then samples once every SLOW_DIV cycles.
// Assumes slow_mode only changes while carrier is low.
module rmii_rx_strobe #(
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_mode,
    input  logic crs_s,
    input  logic rxd_nonzero,
    output logic sample_en
);
    localparam int              CNT_W      = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(SLOW_DIV - 1);

    logic             locked;
    logic [CNT_W-1:0] phase;

    // Sample decision for the current cycle.
    always_comb begin
        if (!crs_s)          sample_en = 1'b0;
        else if (!slow_mode) sample_en = 1'b1;
        else if (!locked)    sample_en = rxd_nonzero;
        else                 sample_en = (phase == LAST_PHASE);
    end

    // Phase counter, locked on the first non-zero dibit of a carrier period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            phase  <= '0;
        end else if (!crs_s || !slow_mode) begin
            locked <= 1'b0;
            phase  <= '0;
        end else if (!locked) begin
            if (rxd_nonzero) begin
                locked <= 1'b1;
                phase  <= '0;
            end
        end else if (phase == LAST_PHASE) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/rmii_rx_framer.sv
// Module: rmii_rx_framer
// Finds the preamble and start-of-frame dibit, then packs sampled dibits
// LSB first into octets. Reports the first octet, the end of an aligned frame,
// and a partial last octet. All outputs are registered.
// Assumes crs_s and rxd_s are already synchronous and aligned to each other.
module rmii_rx_framer
    import rmii_rx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               crs_s,
    input  logic               sample_en,
    input  logic [DIBIT_W-1:0] rxd_s,
    output logic               byte_valid,
    output logic [BYTE_W-1:0]  byte_data,
    output logic               frame_start,
    output logic               frame_end,
    output logic               align_err
);
    localparam int               DPB      = BYTE_W / DIBIT_W;
    localparam int               IDX_W    = (DPB > 1) ? $clog2(DPB) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DPB - 1);

    rx_state_e         state;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] merged;
    logic              first_pending;

    // Partial octet with the current dibit placed at its slot.
    always_comb begin
        merged = shreg;
        merged[idx*DIBIT_W +: DIBIT_W] = rxd_s;
    end

    // Alignment state machine, packing and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= RX_IDLE;
            idx           <= '0;
            shreg         <= '0;
            first_pending <= 1'b0;
            byte_valid    <= 1'b0;
            byte_data     <= '0;
            frame_start   <= 1'b0;
            frame_end     <= 1'b0;
            align_err     <= 1'b0;
        end else begin
            byte_valid  <= 1'b0;
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            align_err   <= 1'b0;
            if (!crs_s) begin
                if (state == RX_DATA) begin
                    frame_end <= 1'b1;
                    align_err <= (idx != '0);
                end
                state         <= RX_IDLE;
                idx           <= '0;
                first_pending <= 1'b0;
            end else if (sample_en) begin
                unique case (state)
                    RX_IDLE, RX_HUNT: begin
                        state <= (rxd_s == DIBIT_PREAMBLE) ? RX_PRE : RX_HUNT;
                    end
                    RX_PRE: begin
                        if (rxd_s == DIBIT_SFD) begin
                            state         <= RX_DATA;
                            idx           <= '0;
                            first_pending <= 1'b1;
                        end else if (rxd_s != DIBIT_PREAMBLE) begin
                            state <= RX_HUNT;
                        end
                    end
                    RX_DATA: begin
                        shreg <= merged;
                        if (idx == LAST_IDX) begin
                            byte_valid    <= 1'b1;
                            byte_data     <= merged;
                            frame_start   <= first_pending;
                            first_pending <= 1'b0;
                            idx           <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end else if (state == RX_IDLE) begin
                state <= RX_HUNT;
            end
        end
    end
endmodule

// File: rtl/rmii_rx_assembler.sv
// Module: rmii_rx_assembler (top)
// MAC-side RMII receive path: synchronizer, rate strobe and framer in a chain.
// Assumes a continuous reference clock on clk and that rate_10m is changed
// only while carrier-valid is low.
module rmii_rx_assembler #(
    parameter int BYTE_W      = 8,
    parameter int SLOW_DIV    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_10m,
    input  logic              crs_dv_in,
    input  logic [1:0]        rxd_in,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              frame_start,
    output logic              frame_end,
    output logic              align_err
);
    import rmii_rx_pkg::*;

    logic               crs_s;
    logic [DIBIT_W-1:0] rxd_s;
    logic               sample_en;

    rmii_rx_sync #(
        .STAGES (SYNC_STAGES),
        .DW     (DIBIT_W)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .crs_in (crs_dv_in),
        .rxd_in (rxd_in),
        .crs_s  (crs_s),
        .rxd_s  (rxd_s)
    );

    rmii_rx_strobe #(
        .SLOW_DIV (SLOW_DIV)
    ) u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_mode   (rate_10m),
        .crs_s       (crs_s),
        .rxd_nonzero (|rxd_s),
        .sample_en   (sample_en)
    );

    rmii_rx_framer #(
        .BYTE_W (BYTE_W)
    ) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .crs_s       (crs_s),
        .sample_en   (sample_en),
        .rxd_s       (rxd_s),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .align_err   (align_err)
    );
endmodule

// File: rtl/rmii_rx_assembler_chk.sv
// Module: rmii_rx_assembler_chk
// Port-level temporal checks on the receive assembler, attached by bind.
// Assumes the default two-stage synchronizer depth unless overridden.
module rmii_rx_assembler_chk #(
    parameter int SLOW_DIV    = 10,
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic rate_10m,
    input logic crs_dv_in,
    input logic byte_valid,
    input logic frame_start,
    input logic frame_end,
    input logic align_err
);
    localparam int               MIN_GAP = 4 * SLOW_DIV - 1;
    localparam int               GAP_W   = $clog2(MIN_GAP + 2) + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    logic [GAP_W-1:0] gap;
    logic             seen_byte;

    // Cycles since the last byte strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap       <= '0;
            seen_byte <= 1'b0;
        end else if (byte_valid) begin
            gap       <= '0;
            seen_byte <= 1'b1;
        end else if (gap != GAP_MAX) begin
            gap <= gap + 1'b1;
        end
    end

    // R7: end-of-frame is a single-cycle pulse.
    a_r7_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R8: an alignment error only comes with an end of frame.
    a_r8_err_with_end: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> frame_end);

    // R6: a frame start only comes with a byte.
    a_r6_start_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> byte_valid);

    // R1: a byte traces back to carrier being high at its sampling edge.
    a_r1_byte_has_carrier: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(crs_dv_in, SYNC_STAGES + 1));

    // R3: with carrier low long enough, no byte or start comes out.
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!crs_dv_in && !$past(crs_dv_in) && !$past(crs_dv_in, 2) && !$past(crs_dv_in, 3))
        |-> (!byte_valid && !frame_start));

    // R9: in slow mode bytes are at least four sample periods apart.
    a_r9_slow_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && rate_10m && seen_byte) |-> (gap >= GAP_W'(MIN_GAP)));
endmodule

bind rmii_rx_assembler rmii_rx_assembler_chk #(
    .SLOW_DIV    (SLOW_DIV),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_10m    (rate_10m),
    .crs_dv_in   (crs_dv_in),
    .byte_valid  (byte_valid),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .align_err   (align_err)
);

// File: tb/rmii_rx_assembler_tb.sv
`timescale 1ns/1ps
module rmii_rx_assembler_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rate_10m;
    logic       crs_dv_in;
    logic [1:0] rxd_in;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       frame_start;
    logic       frame_end;
    logic       align_err;

    always #2 clk = ~clk;

    rmii_rx_assembler u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_10m    (rate_10m),
        .crs_dv_in   (crs_dv_in),
        .rxd_in      (rxd_in),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .align_err   (align_err)
    );

    typedef struct packed {
        logic       bv;
        logic [7:0] b;
        logic       fs;
        logic       fe;
        logic       err;
    } ev_t;

    ev_t        pipe [3];
    string      tagp [3];
    int         n_checks = 0;
    int         n_fail   = 0;
    bit         done     = 1'b0;
    logic [1:0] dq [0:255];
    int         dlen;

    // Compare the outputs with one expected event (R1: fixed three-edge latency).
    task automatic compare(input ev_t e, input string tag);
        n_checks++;
        if (byte_valid !== e.bv || (e.bv && byte_data !== e.b)) begin
            n_fail++;
            $display("FAIL R5 [%s] byte_valid/byte_data actual=%0b/%02h expected=%0b/%02h",
                     tag, byte_valid, byte_data, e.bv, e.b);
        end
        if (frame_start !== e.fs) begin
            n_fail++;
            $display("FAIL R6 [%s] frame_start actual=%0b expected=%0b", tag, frame_start, e.fs);
        end
        if (frame_end !== e.fe) begin
            n_fail++;
            $display("FAIL R7 [%s] frame_end actual=%0b expected=%0b", tag, frame_end, e.fe);
        end
        if (align_err !== e.err) begin
            n_fail++;
            $display("FAIL R8 [%s] align_err actual=%0b expected=%0b", tag, align_err, e.err);
        end
    endtask

    // One cycle: check the result due now, then drive the next inputs.
    task automatic step(input logic c, input logic [1:0] d, input ev_t ev, input string tag);
        @(negedge clk);
        compare(pipe[2], tagp[2]);
        pipe[2] = pipe[1]; tagp[2] = tagp[1];
        pipe[1] = pipe[0]; tagp[1] = tagp[0];
        pipe[0] = ev;      tagp[0] = tag;
        crs_dv_in = c;
        rxd_in    = d;
    endtask

    // Carrier low with random out-of-band values on the data pins (R3).
    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 2'($urandom), '0, tag);
    endtask

    // Index of the aligning 11 by the R4/R11 rule, or -1.
    function automatic int find_sfd();
        bit in_pre = 1'b0;
        for (int i = 0; i < dlen; i++) begin
            if (!in_pre) begin
                if (dq[i] == 2'b01) in_pre = 1'b1;
            end else if (dq[i] == 2'b11) begin
                return i;
            end else if (dq[i] != 2'b01) begin
                in_pre = 1'b0;
            end
        end
        return -1;
    endfunction

    task automatic add(input logic [1:0] d);
        dq[dlen] = d;
        dlen++;
    endtask

    task automatic add_byte(input logic [7:0] b);
        for (int k = 0; k < 4; k++) add(b[2*k +: 2]);
    endtask

    // Drive the dibit list with each dibit held 'hold' cycles, then carrier low.
    task automatic send_frame(input int hold, input string tag);
        int  sfd;
        int  pos;
        ev_t ev;
        sfd = find_sfd();
        for (int i = 0; i < dlen; i++) begin
            for (int h = 0; h < hold; h++) begin
                ev  = '0;
                pos = i - sfd - 1;
                if (h == 0 && sfd >= 0 && i > sfd && (pos % 4) == 3) begin
                    ev.bv = 1'b1;
                    ev.b  = {dq[i], dq[i-1], dq[i-2], dq[i-3]};
                    ev.fs = (pos == 3);
                end
                step(1'b1, dq[i], ev, tag);
            end
        end
        ev = '0;
        if (sfd >= 0) begin
            ev.fe  = 1'b1;
            ev.err = ((dlen - sfd - 1) % 4) != 0;
        end
        step(1'b0, 2'($urandom), ev, tag);
        idle(4 + int'($urandom % 4), tag);
    endtask

    // Random frame: leading zeros (R2), preamble, 11, bytes, optional tail.
    task automatic build_random(input int max_bytes);
        int nz;
        int np;
        int nb;
        int nt;
        dlen = 0;
        nz = int'($urandom % 4);
        np = 1 + int'($urandom % 7);
        nb = int'($urandom % (max_bytes + 1));
        nt = int'($urandom % 4);
        for (int i = 0; i < nz; i++) add(2'b00);
        for (int i = 0; i < np; i++) add(2'b01);
        add(2'b11);
        for (int i = 0; i < nb; i++) add_byte(8'($urandom));
        for (int i = 0; i < nt; i++) add(2'($urandom));
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 3; i++) begin
            pipe[i] = '0;
            tagp[i] = "R10";
        end
        rst_n = 1'b0; rate_10m = 1'b0; crs_dv_in = 1'b0; rxd_in = 2'b00;
        repeat (4) @(negedge clk);
        // R10: outputs low in reset
        compare('0, "R10 reset");
        rst_n = 1'b1;
        idle(4, "R10 after reset");

        // R2, R5: forced zeros then a known byte pattern
        rate_10m = 1'b0;
        dlen = 0;
        for (int i = 0; i < 3; i++) add(2'b00);
        for (int i = 0; i < 7; i++) add(2'b01);
        add(2'b11);
        add_byte(8'hD5); add_byte(8'h00); add_byte(8'hFF); add_byte(8'h1E);
        send_frame(1, "R2 zeros+R5 pack");

        // R4: closing dibit without preamble, no output at all
        dlen = 0;
        add(2'b11); add_byte(8'hA5); add_byte(8'h5A);
        send_frame(1, "R4 no preamble");

        // R11: preamble broken by 10 before the 11, no alignment
        dlen = 0;
        add(2'b01); add(2'b01); add(2'b10); add(2'b11);
        add_byte(8'h3C); add_byte(8'hC3);
        send_frame(1, "R11 broken");

        // R11: preamble restarted after a break, then aligns
        dlen = 0;
        add(2'b01); add(2'b00); add(2'b01); add(2'b11);
        add_byte(8'h96); add_byte(8'h69);
        send_frame(1, "R11 restart");

        // R8: two dibits after the 11 then carrier drop
        dlen = 0;
        add(2'b01); add(2'b11); add(2'b10); add(2'b01);
        send_frame(1, "R8 short");

        // R8: one byte plus one extra dibit
        dlen = 0;
        add(2'b01); add(2'b11); add_byte(8'h81); add(2'b11);
        send_frame(1, "R8 one+1");

        // R7: carrier drops right after the 11, end without error
        dlen = 0;
        add(2'b01); add(2'b01); add(2'b11);
        send_frame(1, "R7 empty");

        // R3: long idle with out-of-band values
        idle(20, "R3 oob");

        // Random full-rate frames
        for (int f = 0; f < 30; f++) begin
            build_random(8);
            send_frame(1, "R5 random 100M");
        end

        // R9: slow mode, directed then random
        rate_10m = 1'b1;
        dlen = 0;
        add(2'b00); add(2'b00);
        for (int i = 0; i < 3; i++) add(2'b01);
        add(2'b11); add_byte(8'h4B); add_byte(8'hB4);
        send_frame(10, "R9 slow directed");
        for (int f = 0; f < 6; f++) begin
            build_random(4);
            send_frame(10, "R9 slow random");
        end

        // Back to full rate once more
        rate_10m = 1'b0;
        build_random(6);
        send_frame(1, "R5 after slow");
        idle(6, "R3 tail");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule